// File: doc/BRIEF.md
# Receive Character Buffer with Fill Threshold and Idle Timeout

This block is the receive-side store of a serial port. A receiver shift register hands it one character at a time, with that character's parity, framing and break flags. The block keeps up to sixteen characters in arrival order and presents the oldest one, with its own flags, at the head. The CPU side pops the head with a read strobe. The flags of a character show only while that character is at the head.

Two interrupt-style flags are produced. The trigger flag is raised when the fill level reaches a threshold picked by a 2-bit code. The timeout flag is raised when characters have been sitting in the buffer for four character-times with no new arrival and no CPU read. A one-cycle character-time tick comes from outside.

Control writes enable the buffer, flush it and load the threshold code. Several other conditions are also flagged:
- a character that arrives when the buffer is full (overrun);
- a break condition, which stores a single zero character and then blocks further stores until the line is re-armed;
- any stored character that carries an error (a summary flag, cleared by a status read).

Top module: `rxq_buffer`

## Requirements
- R1: The buffer holds 16 characters and returns them in arrival order. `fill` reports the number stored. A pop strobe on an empty buffer has no effect, and `fill` stays 0.
- R2: The threshold code maps as follows: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters. `trig` is high exactly while `fill` is at or above the threshold of the most recently loaded code.
- R3: `tmo` rises once four `char_tick` pulses have arrived while the buffer is non-empty, with no store and no pop since the timer last restarted. It stays high while that condition persists. It is never high while the buffer is empty.
- R4: Each stored character and each pop strobe restarts the idle timer. A pop strobe clears a pending `tmo` on the next cycle.
- R5: A character that arrives when the buffer is full, with no pop in the same cycle, is dropped. The stored contents and `fill` are unchanged. `overrun` becomes 1 and stays 1 until a `st_rd` strobe.
- R6: `head_perr`, `head_ferr` and `head_brk` carry the flags stored with the character currently at the head. A flagged character deeper in the buffer does not show on these outputs.
- R7: `data_ready` is 1 from the cycle after the first character is stored until the buffer becomes empty.
- R8: These control writes empty the buffer and zero `fill`:
  - a write with `cfg_en`=1 and `cfg_flush`=1;
  - any write with `cfg_en`=0.

  After a write with `cfg_en`=0, arriving characters are ignored until a write with `cfg_en`=1. The threshold code is loaded only by a write with `cfg_en`=1.
- R9: A character arriving with `chr_brk`=1 is stored as data 0x00 with `head_brk` set. Later characters are then ignored (no store and no overrun) until a `line_rearm` pulse.
- R10: A store and a pop in the same cycle leave `fill` unchanged. This holds also when the buffer is full, in which case no overrun is flagged.
- R11: `err_any` becomes 1 in the cycle after a character with any error flag is stored. It stays 1 until a `st_rd` strobe or a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is offered |
| chr_data | input | 8 | Received character |
| chr_perr | input | 1 | Parity error of the offered character |
| chr_ferr | input | 1 | Framing error of the offered character |
| chr_brk | input | 1 | The offered character is a break indication |
| line_rearm | input | 1 | Line back at mark with a valid start bit; unblocks stores after a break |
| rd_pop | input | 1 | CPU read strobe; removes the head character |
| st_rd | input | 1 | Status read strobe; clears overrun and the error summary |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable bit of the control write |
| cfg_flush | input | 1 | Flush bit of the control write (self-clearing action) |
| cfg_lvl | input | 2 | Threshold code of the control write |
| char_tick | input | 1 | One-cycle pulse per character-time |
| head_data | output | 8 | Character at the head |
| head_perr | output | 1 | Parity flag of the head character |
| head_ferr | output | 1 | Framing flag of the head character |
| head_brk | output | 1 | Break flag of the head character |
| fill | output | 5 | Number of stored characters (0 to 16) |
| data_ready | output | 1 | At least one character stored |
| overrun | output | 1 | A character was dropped because the buffer was full |
| trig | output | 1 | Fill level at or above the threshold |
| tmo | output | 1 | Idle timeout with data present |
| err_any | output | 1 | An errored character was stored since the last status read |

## Verification
The bench sweeps every threshold code while filling the buffer from empty to full and draining it. At each step it checks that `trig` follows the level. A design with an off-by-one comparison would flip the flag one character early or late. At full, it offers one more character. A design that overwrote the tail or advanced the count would corrupt the drained sequence or report 17.

The timeout is probed with exactly three and then four ticks, and again after a restart by a store and by a pop. A timer that did not restart, or that counted one tick too few, would raise `tmo` at the wrong tick.

Break blocking, flags seen only at the head, simultaneous store and pop at a partial and a full level, and stores while disabled are each driven. A design that leaked a buried flag to the head outputs, or that counted a blocked character as an overrun, shows up as a wrong port value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxq_ent_t;

  // Threshold in characters for a 2-bit level code.
  function automatic logic [4:0] lvl_thr(input logic [1:0] code);
    case (code)
      2'd0:    lvl_thr = 5'd1;
      2'd1:    lvl_thr = 5'd4;
      2'd2:    lvl_thr = 5'd8;
      default: lvl_thr = 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  rxq_ent_t      din,
  output rxq_ent_t      head,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  rxq_ent_t        mem [DEPTH];
  logic [AW-1:0]   wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else if (clr) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = mem[rp];
  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
  parameter int LIMIT = 4,
  parameter int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic idle_zero,
  input  logic tick,
  output logic expired
);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart || idle_zero) cnt <= '0;
    else if (tick && cnt != LIM)   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int IDLE_TICKS = 4,
  parameter int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [7:0]    chr_data,
  input  logic          chr_perr,
  input  logic          chr_ferr,
  input  logic          chr_brk,
  input  logic          line_rearm,
  input  logic          rd_pop,
  input  logic          st_rd,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_flush,
  input  logic [1:0]    cfg_lvl,
  input  logic          char_tick,
  output logic [7:0]    head_data,
  output logic          head_perr,
  output logic          head_ferr,
  output logic          head_brk,
  output logic [CW-1:0] fill,
  output logic          data_ready,
  output logic          overrun,
  output logic          trig,
  output logic          tmo,
  output logic          err_any
);
  logic     en_q, hold_q;
  logic [1:0] lvl_q;
  logic     full, empty;
  rxq_ent_t head, din;

  // Named internal events
  logic cfg_clr, take_ev, push_ev, pop_ev, drop_ev, bad_ev, restart_ev;

  assign cfg_clr    = cfg_wr && (!cfg_en || cfg_flush);
  assign pop_ev     = rd_pop && !empty && !cfg_clr;
  assign take_ev    = chr_valid && en_q && !hold_q && !cfg_clr;
  assign push_ev    = take_ev && (!full || pop_ev);
  assign drop_ev    = take_ev && full && !pop_ev;
  assign bad_ev     = push_ev && (chr_perr || chr_ferr || chr_brk);
  assign restart_ev = push_ev || rd_pop || cfg_clr;

  always_comb begin
    din.brk  = chr_brk;
    din.ferr = chr_ferr;
    din.perr = chr_perr;
    din.data = chr_brk ? 8'h00 : chr_data;
  end

  rxq_store #(.DEPTH(DEPTH), .CW(CW)) store_i (
    .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .push(push_ev), .pop(pop_ev),
    .din(din), .head(head), .fill(fill), .full(full), .empty(empty)
  );

  rxq_idle #(.LIMIT(IDLE_TICKS)) idle_i (
    .clk(clk), .rst_n(rst_n), .restart(restart_ev), .idle_zero(empty),
    .tick(char_tick), .expired(tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lvl_q   <= 2'd0;
      hold_q  <= 1'b0;
      overrun <= 1'b0;
      err_any <= 1'b0;
    end else begin
      if (cfg_wr)           en_q  <= cfg_en;
      if (cfg_wr && cfg_en) lvl_q <= cfg_lvl;
      if (take_ev && chr_brk) hold_q <= 1'b1;
      else if (line_rearm)    hold_q <= 1'b0;
      if (drop_ev)    overrun <= 1'b1;
      else if (st_rd) overrun <= 1'b0;
      if (bad_ev)                err_any <= 1'b1;
      else if (st_rd || cfg_clr) err_any <= 1'b0;
    end
  end

  assign head_data  = head.data;
  assign head_perr  = head.perr;
  assign head_ferr  = head.ferr;
  assign head_brk   = head.brk;
  assign data_ready = !empty;
  assign trig       = fill >= CW'(lvl_thr(lvl_q));

  assert_full_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && en_q && !hold_q && !cfg_wr && !rd_pop && fill == CW'(DEPTH))
      |=> (fill == CW'(DEPTH) && overrun));

  assert_trig_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !rd_pop && !cfg_wr) |=> trig);

  assert_tmo_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> data_ready);

  assert_pop_clears_tmo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !tmo);

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !rd_pop && !cfg_wr) |=> data_ready);

  assert_break_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cfg_wr && !rd_pop) |=> $stable(fill));

  assert_both_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && pop_ev) |=> $stable(fill));

endmodule

// File: tb/rxq_buffer_tb_top.sv
module rxq_buffer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_valid = 0, chr_perr = 0, chr_ferr = 0, chr_brk = 0, line_rearm = 0;
  logic [7:0] chr_data = 0;
  logic rd_pop = 0, st_rd = 0, cfg_wr = 0, cfg_en = 0, cfg_flush = 0, char_tick = 0;
  logic [1:0] cfg_lvl = 0;
  logic [7:0] head_data;
  logic head_perr, head_ferr, head_brk, data_ready, overrun, trig, tmo, err_any;
  logic [4:0] fill;

  int checks = 0, errors = 0;
  logic [10:0] q[$];
  bit m_en = 0, m_hold = 0, m_ovr = 0, m_err = 0;
  int m_lvl = 0;

  always #5 clk = ~clk;

  rxq_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_brk(chr_brk),
    .line_rearm(line_rearm), .rd_pop(rd_pop), .st_rd(st_rd), .cfg_wr(cfg_wr),
    .cfg_en(cfg_en), .cfg_flush(cfg_flush), .cfg_lvl(cfg_lvl),
    .char_tick(char_tick), .head_data(head_data), .head_perr(head_perr),
    .head_ferr(head_ferr), .head_brk(head_brk), .fill(fill),
    .data_ready(data_ready), .overrun(overrun), .trig(trig), .tmo(tmo),
    .err_any(err_any)
  );

  function automatic int thr_of(int code);
    if (code == 0) return 1;
    if (code == 3) return 14;
    return 4 * code;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R1 fill"}, int'(fill), q.size());
    chk({tag, " R7 data_ready"}, int'(data_ready), int'(q.size() > 0));
    chk({tag, " R2 trig"}, int'(trig), int'(q.size() >= thr_of(m_lvl)));
    chk({tag, " R5 overrun"}, int'(overrun), int'(m_ovr));
    chk({tag, " R11 err_any"}, int'(err_any), int'(m_err));
    if (q.size() > 0)
      chk({tag, " R6 head"}, int'({head_brk, head_ferr, head_perr, head_data}),
          int'(q[0]));
  endtask

  task automatic cfg(bit en, bit fl, int lvl);
    cfg_wr = 1; cfg_en = en; cfg_flush = fl; cfg_lvl = 2'(lvl);
    step();
    cfg_wr = 0; cfg_en = 0; cfg_flush = 0; cfg_lvl = 0;
    if (!en || fl) begin q.delete(); m_err = 0; end
    m_en = en;
    if (en) m_lvl = lvl;
  endtask

  task automatic model_push(logic [7:0] d, bit p, bit f, bit b, bit popping);
    if (m_en && !m_hold) begin
      if (q.size() == 16 && !popping) m_ovr = 1;
      else begin
        q.push_back({b, f, p, (b ? 8'h00 : d)});
        if (p || f || b) m_err = 1;
      end
      if (b) m_hold = 1;
    end
  endtask

  task automatic push(logic [7:0] d, bit p = 0, bit f = 0, bit b = 0);
    chr_valid = 1; chr_data = d; chr_perr = p; chr_ferr = f; chr_brk = b;
    step();
    chr_valid = 0; chr_perr = 0; chr_ferr = 0; chr_brk = 0;
    model_push(d, p, f, b, 0);
  endtask

  task automatic pop();
    rd_pop = 1;
    step();
    rd_pop = 0;
    if (q.size() > 0) void'(q.pop_front());
  endtask

  task automatic both(logic [7:0] d);
    chr_valid = 1; chr_data = d; rd_pop = 1;
    step();
    chr_valid = 0; rd_pop = 0;
    if (q.size() > 0) void'(q.pop_front());
    model_push(d, 0, 0, 0, 1);
  endtask

  task automatic status_read();
    st_rd = 1; step(); st_rd = 0;
    m_ovr = 0; m_err = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1; step(); char_tick = 0; step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check_all("reset");
    chk("reset R3 tmo", int'(tmo), 0);

    // R1 R2 R5: sweep every threshold code over a full fill and drain
    for (int lv = 0; lv < 4; lv++) begin
      cfg(1, 1, lv);
      check_all("sweep flush");
      for (int i = 0; i < 16; i++) begin
        push(8'(i * 7 + lv * 3 + 1));
        check_all("sweep fill");
      end
      push(8'hEE);
      check_all("sweep overrun R5");
      status_read();
      check_all("sweep st_rd R5");
      for (int i = 0; i < 16; i++) begin
        pop();
        check_all("sweep drain");
      end
      pop();
      check_all("R1 empty pop");
    end

    // R10: simultaneous store and pop, partial and full
    cfg(1, 1, 1);
    for (int i = 0; i < 5; i++) push(8'(8'h40 + i));
    both(8'h99);
    check_all("R10 partial");
    for (int i = 0; i < 11; i++) push(8'(8'h60 + i));
    both(8'h77);
    check_all("R10 full");
    for (int i = 0; i < 16; i++) begin pop(); check_all("R10 drain"); end

    // R6 R11: flags visible only at the head
    cfg(1, 1, 0);
    push(8'h11); push(8'h22, 1, 0, 0); push(8'h33, 0, 1, 0);
    check_all("R6 buried");
    chk("R6 head_perr buried", int'(head_perr), 0);
    pop(); check_all("R6 perr head");
    chk("R6 head_perr at head", int'(head_perr), 1);
    pop(); check_all("R6 ferr head");
    status_read(); check_all("R11 cleared");
    pop();

    // R9: break stores zero and blocks
    push(8'h55, 0, 0, 1);
    check_all("R9 break stored");
    push(8'h66);
    check_all("R9 blocked");
    line_rearm = 1; step(); line_rearm = 0; m_hold = 0;
    push(8'h44);
    check_all("R9 rearmed");
    status_read();

    // R3 R4: idle timeout
    cfg(1, 1, 3);
    push(8'h01); push(8'h02);
    ticks(3); chk("R3 three ticks", int'(tmo), 0);
    ticks(1); chk("R3 four ticks", int'(tmo), 1);
    ticks(2); chk("R3 stays", int'(tmo), 1);
    pop(); chk("R4 pop clears", int'(tmo), 0);
    ticks(3); push(8'h03); ticks(3);
    chk("R4 store restarts", int'(tmo), 0);
    ticks(1); chk("R3 after restart", int'(tmo), 1);
    pop(); pop(); check_all("R3 emptied");
    ticks(5); chk("R3 empty no tmo", int'(tmo), 0);

    // R8: flush and disable
    for (int i = 0; i < 3; i++) push(8'(i));
    cfg(1, 1, 0); check_all("R8 flush");
    push(8'hA0); push(8'hA1);
    cfg(0, 0, 3); check_all("R8 disable empties");
    push(8'hA2); check_all("R8 disabled ignores");
    cfg(1, 0, 2);
    for (int i = 0; i < 8; i++) push(8'(i));
    check_all("R8 level loaded");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule